// File: doc/BRIEF.md
# Quadrant bank-select decoder for a 64K memory board

The decoder picks which of four 16K quadrants of a memory board answers a 16-bit memory address. The two top address bits name the quadrant. A build-size input says how many quadrants are actually populated, and a quadrant that is not populated never answers. A phantom input makes the whole board stay silent, so that another device can overlay its range.

In normal mode every populated quadrant answers at its fixed range. In bank mode, a 4-bit disable mask is held in a register. Software writes that register through an I/O port whose 8-bit address is set by configuration. A set bit turns its quadrant off. This lets several boards share one address space, each switched in or out by software. Register writes are accepted only while the I/O enable input is high. The selects are combinational from the address, the mode, the mask and the phantom input. A register write changes them from the next clock edge on.

Top module: `bank_decoder`

## Requirements
- R1: The quadrant index is mem_addr[15:14]: 0 covers 0000-3FFF, 1 covers 4000-7FFF, 2 covers 8000-BFFF and 3 covers C000-FFFF. At most one bit of bank_sel is high, and it is the bit of that index. board_hit is high exactly when any bank_sel bit is high.
- R2: With cfg_bank_mode=0, every populated quadrant answers at every address in its range, whatever the mask register holds.
- R3: With cfg_bank_mode=1, mask bit n (n=0..3) set to 1 disables quadrant n, and set to 0 enables it.
- R4: A mask of 0xF silences the whole board in bank mode. A mask of 0x0 makes all of 0000-FFFF answer.
- R5: Reset (rst_n low, asynchronous) clears the mask to 0x0, so the whole board answers in bank mode.
- R6: A port write loads the mask only when io_addr equals cfg_port_addr on all eight bits. Any difference leaves the mask unchanged.
- R7: With cfg_io_en=0, a port write is ignored and the mask is unchanged.
- R8: An accepted write changes the selects from the first rising edge after the cycle in which io_wr_stb is high. During the strobe cycle the old mask still applies. Changes on mem_addr, cfg_bank_mode and phantom act in the same cycle.
- R9: io_wdata[7:4] has no effect. Only io_wdata[3:0] is loaded.
- R10: While phantom is high, bank_sel is 0 and board_hit is 0.
- R11: cfg_size encodes how many quadrants are populated. 0 means quadrants 0-3 (64K), 1 means 0-2 (48K), 2 means 0-1 (32K), and 3 means quadrant 0 only (16K). An unpopulated quadrant never answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on clear |
| cfg_bank_mode | input | 1 | 0 = normal mode, 1 = bank mode |
| cfg_io_en | input | 1 | Allows port writes to load the mask |
| cfg_port_addr | input | 8 | I/O address of the mask port |
| cfg_size | input | 2 | Populated quadrants (encoding in R11) |
| phantom | input | 1 | High silences the whole board |
| mem_addr | input | 16 | Memory address being decoded |
| io_wr_stb | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data; bits 3:0 form the mask |
| bank_sel | output | 4 | One select per quadrant |
| board_hit | output | 1 | Board answers the current address |

## Verification
The selects and board_hit are due in the same cycle as any change on the address, mode, size or phantom input. A mask write is due one rising edge after its strobe cycle. The bench changes inputs on the falling edge and compares 5 ns later, well before the next rising edge. Its reference model updates its mask on that rising edge, so the strobe cycle is compared against the old mask and the cycle after it against the new one. A reference reset that follows rst_n at once covers the asynchronous clear.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  typedef enum logic [1:0] {
    SZ_FULL   = 2'd0,
    SZ_NO_TOP = 2'd1,
    SZ_HALF   = 2'd2,
    SZ_SINGLE = 2'd3
  } size_e;

  function automatic int unsigned fitted_count(input int unsigned n_banks, input size_e sz);
    int unsigned drop;
    drop = int'(sz);
    return (drop >= n_banks) ? 1 : n_banks - drop;
  endfunction
endpackage

// File: rtl/qbd_port_reg.sv
module qbd_port_reg #(
  parameter int IO_ADDR_W = 8,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_en,
  input  logic                 wr_stb,
  input  logic [IO_ADDR_W-1:0] wr_addr,
  input  logic [IO_ADDR_W-1:0] match_addr,
  input  logic [NUM_BANKS-1:0] wr_mask,
  output logic [NUM_BANKS-1:0] off_q
);
  logic take;

  assign take = wr_stb && io_en && (wr_addr == match_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (take) off_q <= wr_mask;
  end
endmodule

// File: rtl/qbd_fit_mask.sv
module qbd_fit_mask
  import qbd_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  size_e                size_cfg,
  output logic [NUM_BANKS-1:0] fitted
);
  int unsigned count;

  assign count = fitted_count(NUM_BANKS, size_cfg);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_fit
    assign fitted[i] = (i < count);
  end
endmodule

// File: rtl/qbd_bank_decode.sv
module qbd_bank_decode #(
  parameter int BANK_BITS = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic [BANK_BITS-1:0] bank_idx,
  input  logic                 bank_mode,
  input  logic                 phantom,
  input  logic [NUM_BANKS-1:0] off_mask,
  input  logic [NUM_BANKS-1:0] fitted,
  output logic [NUM_BANKS-1:0] sel
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit_idx;
    logic allowed;
    assign hit_idx = (bank_idx == BANK_BITS'(i));
    assign allowed = fitted[i] && (!bank_mode || !off_mask[i]);
    assign sel[i]  = hit_idx && allowed && !phantom;
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import qbd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int IO_ADDR_W = 8,
  parameter int DATA_W    = 8,
  localparam int NUM_BANKS = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_bank_mode,
  input  logic                 cfg_io_en,
  input  logic [IO_ADDR_W-1:0] cfg_port_addr,
  input  logic [1:0]           cfg_size,
  input  logic                 phantom,
  input  logic [ADDR_W-1:0]    mem_addr,
  input  logic                 io_wr_stb,
  input  logic [IO_ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0]    io_wdata,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic                 board_hit
);
  logic [BANK_BITS-1:0] bank_idx;
  logic [NUM_BANKS-1:0] bank_off_q;
  logic [NUM_BANKS-1:0] fitted;
  logic                 unused_addr_lo;
  logic                 unused_wdata_hi;

  assign bank_idx        = mem_addr[ADDR_W-1 -: BANK_BITS];
  assign unused_addr_lo  = ^mem_addr[ADDR_W-BANK_BITS-1:0];
  assign unused_wdata_hi = ^io_wdata[DATA_W-1:NUM_BANKS];

  qbd_port_reg #(.IO_ADDR_W(IO_ADDR_W), .NUM_BANKS(NUM_BANKS)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_en      (cfg_io_en),
    .wr_stb     (io_wr_stb),
    .wr_addr    (io_addr),
    .match_addr (cfg_port_addr),
    .wr_mask    (io_wdata[NUM_BANKS-1:0]),
    .off_q      (bank_off_q)
  );

  qbd_fit_mask #(.NUM_BANKS(NUM_BANKS)) u_fit (
    .size_cfg (size_e'(cfg_size)),
    .fitted   (fitted)
  );

  qbd_bank_decode #(.BANK_BITS(BANK_BITS)) u_dec (
    .bank_idx  (bank_idx),
    .bank_mode (cfg_bank_mode),
    .phantom   (phantom),
    .off_mask  (bank_off_q),
    .fitted    (fitted),
    .sel       (bank_sel)
  );

  assign board_hit = |bank_sel;
endmodule

// File: rtl/bank_decoder_chk.sv
module bank_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_bank_mode,
  input logic       cfg_io_en,
  input logic [7:0] cfg_port_addr,
  input logic [1:0] cfg_size,
  input logic       phantom,
  input logic [1:0] bank_idx,
  input logic       io_wr_stb,
  input logic [7:0] io_addr,
  input logic [3:0] wr_low,
  input logic [3:0] bank_off_q,
  input logic [3:0] bank_sel,
  input logic       board_hit
);
  logic populated;
  logic accepted;

  always_comb begin
    case (cfg_size)
      2'd0:    populated = 1'b1;
      2'd1:    populated = (bank_idx != 2'd3);
      2'd2:    populated = !bank_idx[1];
      default: populated = (bank_idx == 2'd0);
    endcase
  end

  assign accepted = io_wr_stb && cfg_io_en && (io_addr == cfg_port_addr);

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));
  p_sel_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    board_hit |-> bank_sel[bank_idx]);
  p_normal_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bank_mode && !phantom && populated) |-> board_hit);
  p_bank_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bank_mode && bank_off_q[bank_idx]) |-> !board_hit);
  p_bank_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bank_mode && !bank_off_q[bank_idx] && populated && !phantom) |-> board_hit);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> $stable(bank_off_q));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> (bank_off_q == $past(wr_low)));
  p_phantom_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phantom |-> (bank_sel == 4'd0));
  p_absent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !populated |-> !board_hit);
endmodule

bind bank_decoder bank_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_bank_mode (cfg_bank_mode),
  .cfg_io_en     (cfg_io_en),
  .cfg_port_addr (cfg_port_addr),
  .cfg_size      (cfg_size),
  .phantom       (phantom),
  .bank_idx      (bank_idx),
  .io_wr_stb     (io_wr_stb),
  .io_addr       (io_addr),
  .wr_low        (io_wdata[3:0]),
  .bank_off_q    (bank_off_q),
  .bank_sel      (bank_sel),
  .board_hit     (board_hit)
);

// File: tb/bank_decoder_tb_top.sv
`timescale 1ns/1ps
module bank_decoder_tb_top;
  localparam logic [7:0] PORT = 8'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_bank_mode = 1'b0;
  logic       cfg_io_en = 1'b1;
  logic [7:0] cfg_port_addr = PORT;
  logic [1:0] cfg_size = 2'd0;
  logic       phantom = 1'b0;
  logic [15:0] mem_addr = 16'h0000;
  logic       io_wr_stb = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic [7:0] io_wdata = 8'h00;
  logic [3:0] bank_sel;
  logic       board_hit;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] model_mask = 4'h0;

  always #10 clk = ~clk;

  bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bank_mode(cfg_bank_mode), .cfg_io_en(cfg_io_en),
    .cfg_port_addr(cfg_port_addr), .cfg_size(cfg_size), .phantom(phantom),
    .mem_addr(mem_addr), .io_wr_stb(io_wr_stb), .io_addr(io_addr), .io_wdata(io_wdata),
    .bank_sel(bank_sel), .board_hit(board_hit)
  );

  // Behavioural reference: mask register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_mask <= 4'h0;
    else if (io_wr_stb && cfg_io_en && io_addr == cfg_port_addr) model_mask <= io_wdata[3:0];
  end

  function automatic logic [3:0] expect_sel();
    int idx = int'(mem_addr[15:14]);
    int present = 4 - int'(cfg_size);
    bit on = (idx < present) && (!cfg_bank_mode || !model_mask[idx]) && !phantom;
    return on ? (4'b0001 << idx) : 4'b0000;
  endfunction

  // Called just after a falling edge with inputs already set.
  task automatic cyc(input string tag);
    logic [3:0] es;
    #5;
    es = expect_sel();
    compared++;
    if (bank_sel !== es || board_hit !== (es != 4'd0)) begin
      mismatched++;
      $display("FAIL %s addr=%h sel=%b hit=%b expected sel=%b hit=%b",
               tag, mem_addr, bank_sel, board_hit, es, (es != 4'd0));
    end
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    for (int b = 0; b < 4; b++) begin
      mem_addr = {b[1:0], 14'h2A5B};
      cyc(tag);
    end
  endtask

  task automatic port_write(input logic [7:0] a, input logic [7:0] d, input logic en);
    io_wr_stb = 1'b1; io_addr = a; io_wdata = d; cfg_io_en = en;
    mem_addr = 16'hC123;
    cyc("R8");  // old mask still applies in strobe cycle
    io_wr_stb = 1'b0; cfg_io_en = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cfg_bank_mode = 1'b1;
    sweep("R5");                  // in reset: mask clear, all answer
    rst_n = 1'b1;
    sweep("R5");
    // R4 all off, then all on
    port_write(PORT, 8'h0F, 1'b1);
    sweep("R4");
    port_write(PORT, 8'h00, 1'b1);
    sweep("R4");
    // R3 individual bits
    port_write(PORT, 8'h05, 1'b1);
    sweep("R3");
    port_write(PORT, 8'h0A, 1'b1);
    sweep("R3");
    port_write(PORT, 8'h08, 1'b1);
    sweep("R3");
    // R2 normal mode ignores mask
    port_write(PORT, 8'h0F, 1'b1);
    cfg_bank_mode = 1'b0;
    sweep("R2");
    mem_addr = 16'h0000; cyc("R2");
    mem_addr = 16'hFFFF; cyc("R2");
    cfg_bank_mode = 1'b1;
    sweep("R4");
    // R9 upper data bits ignored
    port_write(PORT, 8'hF0, 1'b1);
    sweep("R9");
    port_write(PORT, 8'h5F, 1'b1);
    sweep("R9");
    // R6 address mismatch in low and high bits
    port_write(PORT ^ 8'h01, 8'h00, 1'b1);
    sweep("R6");
    port_write(PORT ^ 8'h80, 8'h00, 1'b1);
    sweep("R6");
    // R7 io enable off
    port_write(PORT, 8'h00, 1'b0);
    sweep("R7");
    port_write(PORT, 8'h00, 1'b1);
    sweep("R8");
    // R10 phantom
    phantom = 1'b1;
    sweep("R10");
    cfg_bank_mode = 1'b0;
    sweep("R10");
    phantom = 1'b0;
    sweep("R1");
    // R11 build sizes in both modes
    for (int s = 1; s < 4; s++) begin
      cfg_size = s[1:0];
      cfg_bank_mode = 1'b0;
      sweep("R11");
      cfg_bank_mode = 1'b1;
      sweep("R11");
    end
    cfg_size = 2'd0;
    // R1 boundaries of each quadrant
    for (int b = 0; b < 4; b++) begin
      mem_addr = {b[1:0], 14'h0000}; cyc("R1");
      mem_addr = {b[1:0], 14'h3FFF}; cyc("R1");
    end
    // R5 reset mid-run clears the mask
    port_write(PORT, 8'h0F, 1'b1);
    sweep("R4");
    rst_n = 1'b0;
    sweep("R5");
    rst_n = 1'b1;
    sweep("R5");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule